// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Inserter

This block sits in the transmit path of a T1 framer. It steals the least significant bit of each 8-bit channel sample in the signaling frames of a multiframe and replaces it with one bit of that channel's four-bit signaling nibble. In the extended superframe format (24 frames) the four nibble bits A, B, C and D go out in frames 6, 12, 18 and 24. In the 12-frame superframe format only A and B go out, in frames 6 and 12.

Each channel keeps a transmit nibble in a small signaling store. A per-channel source flag selects who may write the store. When the flag is set, only a host register port can write it. When the flag is clear, a serial control stream refreshes it. At each multiframe-start pulse every stored nibble is copied into an active set. Insertion reads only the active set, so all bits sent within one multiframe come from the same nibble. A per-channel clear-channel flag exempts a channel from bit robbing, and a global enable turns insertion on or off for all channels.

Top module: `rbs_inserter`

## Requirements
- R1: While `rob_en` is low, every valid byte is output unchanged.
- R2: Bits 7..1 of a valid byte are always output unchanged. Bit 0 is replaced only when the frame number is 6, 12, 18 or 24. Bytes in all other frames pass unchanged.
- R3: With `esf_sel` high, bit 0 is replaced by nibble bit 3 (A) in frame 6, by bit 2 (B) in frame 12, by bit 1 (C) in frame 18 and by bit 0 (D) in frame 24.
- R4: With `esf_sel` low, bit 0 is replaced by nibble bit 3 (A) in frame 6 and by nibble bit 2 (B) in frame 12. Bytes in frame 18 or frame 24 pass unchanged.
- R5: A byte on a channel whose `clear_ch` bit is set is output unchanged.
- R6: When a channel's `host_src` bit is set, only a host write (`hw_en`) to that channel changes its stored nibble. Stream updates to that channel are ignored.
- R7: When a channel's `host_src` bit is clear, only a stream update (`cs_en`) to that channel changes its stored nibble. Host writes to that channel are ignored.
- R8: If a host write and a stream update address the same channel in the same cycle, the channel's `host_src` bit alone selects which one is stored.
- R9: The nibble used for insertion is the stored nibble as it was just before the most recent `mf_start` cycle. Store updates made after that cycle take effect only at the next `mf_start`.
- R10: `dout` and `dout_vld` are 0 after reset. Each valid byte appears on `dout` one clock later. `dout_vld` follows `din_vld` with one clock delay, and `dout` holds its value while no byte is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rob_en | input | 1 | Global robbed-bit enable |
| esf_sel | input | 1 | 1 = 24-frame format, 0 = 12-frame format |
| mf_start | input | 1 | Multiframe-start pulse; copies the stored nibbles to the active set |
| din_vld | input | 1 | Input byte valid |
| frame_no | input | 5 | Frame number of the byte, 1..24 |
| ch_no | input | 5 | Channel number of the byte, 0..23 |
| din | input | 8 | Channel sample |
| clear_ch | input | 24 | Per-channel clear-channel flags |
| host_src | input | 24 | Per-channel host-source flags |
| hw_en | input | 1 | Host nibble write strobe |
| hw_ch | input | 5 | Host write channel |
| hw_nib | input | 4 | Host write nibble |
| cs_en | input | 1 | Serial-stream nibble update strobe |
| cs_ch | input | 5 | Stream update channel |
| cs_nib | input | 4 | Stream update nibble |
| dout | output | 8 | Output sample |
| dout_vld | output | 1 | Output byte valid |

## Verification
A host write and a stream update can address the same channel in the same clock, and the source flag must decide the result. The bench provokes this on one host-sourced channel and one stream-sourced channel with different nibbles on each path. It then judges the stored value from the robbed bits sent in the next multiframe. A store update can also fall in the same cycle as, or just after, a multiframe-start pulse. The bench changes a nibble after the pulse and checks that the old nibble is still sent. It then checks that the new nibble is sent after the next pulse.

// File: rtl/rbs_pkg.sv
// Shared types and the signaling slot decode for the robbed-bit inserter.
// Assumes frame numbers 1..24; nibble bit 3 = A ... bit 0 = D.
package rbs_pkg;
    localparam int FRAME_W = 5;
    localparam int NIB_W   = 4;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [NIB_W-1:0]   nib_t;

    typedef struct packed {
        logic       hit;   // this frame carries a signaling bit
        logic [1:0] pos;   // 0=A 1=B 2=C 3=D
    } slot_t;

    // Decode which signaling bit (if any) a frame carries in the selected format.
    function automatic slot_t sig_slot(input frame_t frame, input logic esf);
        slot_t s;
        s = '0;
        case (frame)
            frame_t'(6):  begin s.hit = 1'b1; s.pos = 2'd0; end
            frame_t'(12): begin s.hit = 1'b1; s.pos = 2'd1; end
            frame_t'(18): begin s.hit = esf;  s.pos = 2'd2; end
            frame_t'(24): begin s.hit = esf;  s.pos = 2'd3; end
            default:      s = '0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/rbs_sig_mem.sv
// Transmit signaling store: one nibble per channel. The per-channel source flag
// picks the only write path that may change that channel (host or stream).
// Assumes write channel numbers >= NUM_CH are dropped.
module rbs_sig_mem
    import rbs_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       host_src,
    input  logic                    hw_en,
    input  logic [CH_W-1:0]         hw_ch,
    input  nib_t                    hw_nib,
    input  logic                    cs_en,
    input  logic [CH_W-1:0]         cs_ch,
    input  nib_t                    cs_nib,
    output logic [NUM_CH*NIB_W-1:0] mem_flat
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic host_hit;
        logic strm_hit;
        nib_t mem_q;

        assign host_hit = hw_en && (hw_ch == CH_W'(i));
        assign strm_hit = cs_en && (cs_ch == CH_W'(i));

        // Update this channel's nibble from the path its source flag selects.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q <= '0;
            else if (host_src[i]) begin
                if (host_hit) mem_q <= hw_nib;
            end else if (strm_hit)
                mem_q <= cs_nib;
        end

        assign mem_flat[i*NIB_W +: NIB_W] = mem_q;

        // R6: a host-sourced channel changes only on a host write
        p_host_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (host_src[i] && !host_hit) |=> (mem_flat[i*NIB_W +: NIB_W] == $past(mem_flat[i*NIB_W +: NIB_W])));
        // R7: a stream-sourced channel changes only on a stream update
        p_strm_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!host_src[i] && !strm_hit) |=> (mem_flat[i*NIB_W +: NIB_W] == $past(mem_flat[i*NIB_W +: NIB_W])));
    end
endmodule

// File: rtl/rbs_mf_snap.sv
// Multiframe snapshot: copies the whole signaling store into an active set on the
// multiframe-start pulse and serves the active nibble of the addressed channel.
// Assumes mf_start is a single-cycle pulse; out-of-range channels read 0.
module rbs_mf_snap
    import rbs_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mf_start,
    input  logic [NUM_CH*NIB_W-1:0] mem_flat,
    input  logic [CH_W-1:0]         rd_ch,
    output nib_t                    rd_nib
);
    logic [NUM_CH*NIB_W-1:0] act_q;

    // Capture all nibbles at the start of a multiframe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (mf_start)
            act_q <= mem_flat;
    end

    // Select the active nibble for the current channel.
    always_comb begin
        rd_nib = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (rd_ch == CH_W'(i)) rd_nib = act_q[i*NIB_W +: NIB_W];
    end

    // R9: the active set moves only at a multiframe start
    p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_start |=> (act_q == $past(act_q)));
    // R9: on a multiframe start the active set takes the pre-edge store
    p_snap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mf_start |=> (act_q == $past(mem_flat)));
endmodule

// File: rtl/rbs_bit_robber.sv
// Output stage: replaces bit 0 of a valid byte with the selected signaling bit
// when enabled, in a signaling frame, and on a non-clear channel. One register stage.
module rbs_bit_robber
    import rbs_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rob_en,
    input  logic              esf_sel,
    input  logic              din_vld,
    input  frame_t            frame_no,
    input  logic [CH_W-1:0]   ch_no,
    input  logic [7:0]        din,
    input  logic [NUM_CH-1:0] clear_ch,
    input  nib_t              nib,
    output logic [7:0]        dout,
    output logic              dout_vld
);
    slot_t slot;
    logic  ch_clear;
    logic  rob;
    logic  sig_bit;

    // Decide whether this byte is robbed and which nibble bit it carries.
    always_comb begin
        slot     = sig_slot(frame_no, esf_sel);
        ch_clear = 1'b0;
        for (int i = 0; i < NUM_CH; i++)
            if (ch_no == CH_W'(i)) ch_clear = clear_ch[i];
        rob     = rob_en && slot.hit && !ch_clear;
        sig_bit = nib[2'd3 - slot.pos];
    end

    // Register the output byte and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= din_vld;
            if (din_vld)
                dout <= rob ? {din[7:1], sig_bit} : din;
        end
    end

    // R1: disabled means pass-through
    p_dis_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (din_vld && !rob_en) |=> (dout == $past(din)));
    // R2: upper seven bits never change
    p_upper_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        din_vld |=> (dout[7:1] == $past(din[7:1])));
    // R10: output valid trails input valid by one cycle
    p_vld_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dout_vld == $past(din_vld)));
    // R10: output held while no byte is valid
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !din_vld |=> $stable(dout));
endmodule

// File: rtl/rbs_inserter.sv
// Top of the T1 robbed-bit signaling inserter: signaling store, multiframe
// snapshot and bit-robbing output stage. Assumes frame_no/ch_no arrive with din.
module rbs_inserter
    import rbs_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rob_en,
    input  logic              esf_sel,
    input  logic              mf_start,
    input  logic              din_vld,
    input  logic [4:0]        frame_no,
    input  logic [CH_W-1:0]   ch_no,
    input  logic [7:0]        din,
    input  logic [NUM_CH-1:0] clear_ch,
    input  logic [NUM_CH-1:0] host_src,
    input  logic              hw_en,
    input  logic [CH_W-1:0]   hw_ch,
    input  logic [3:0]        hw_nib,
    input  logic              cs_en,
    input  logic [CH_W-1:0]   cs_ch,
    input  logic [3:0]        cs_nib,
    output logic [7:0]        dout,
    output logic              dout_vld
);
    logic [NUM_CH*NIB_W-1:0] mem_flat;
    nib_t                    act_nib;

    rbs_sig_mem #(.NUM_CH(NUM_CH)) u_mem (
        .clk(clk), .rst_n(rst_n), .host_src(host_src),
        .hw_en(hw_en), .hw_ch(hw_ch), .hw_nib(hw_nib),
        .cs_en(cs_en), .cs_ch(cs_ch), .cs_nib(cs_nib),
        .mem_flat(mem_flat)
    );

    rbs_mf_snap #(.NUM_CH(NUM_CH)) u_snap (
        .clk(clk), .rst_n(rst_n), .mf_start(mf_start),
        .mem_flat(mem_flat), .rd_ch(ch_no), .rd_nib(act_nib)
    );

    rbs_bit_robber #(.NUM_CH(NUM_CH)) u_rob (
        .clk(clk), .rst_n(rst_n), .rob_en(rob_en), .esf_sel(esf_sel),
        .din_vld(din_vld), .frame_no(frame_no), .ch_no(ch_no), .din(din),
        .clear_ch(clear_ch), .nib(act_nib), .dout(dout), .dout_vld(dout_vld)
    );
endmodule

// File: tb/rbs_inserter_tb.sv
module rbs_inserter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rob_en = 1'b0, esf_sel = 1'b1, mf_start = 1'b0, din_vld = 1'b0;
    logic [4:0]  frame_no = '0, ch_no = '0, hw_ch = '0, cs_ch = '0;
    logic [7:0]  din = '0;
    logic [23:0] clear_ch = '0, host_src = '0;
    logic        hw_en = 1'b0, cs_en = 1'b0;
    logic [3:0]  hw_nib = '0, cs_nib = '0;
    logic [7:0]  dout;
    logic        dout_vld;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    rbs_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .rob_en(rob_en), .esf_sel(esf_sel),
        .mf_start(mf_start), .din_vld(din_vld), .frame_no(frame_no),
        .ch_no(ch_no), .din(din), .clear_ch(clear_ch), .host_src(host_src),
        .hw_en(hw_en), .hw_ch(hw_ch), .hw_nib(hw_nib),
        .cs_en(cs_en), .cs_ch(cs_ch), .cs_nib(cs_nib),
        .dout(dout), .dout_vld(dout_vld)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [4:0] f, input logic [4:0] c, input logic [7:0] d,
                        input logic [7:0] exp, input int req);
        @(negedge clk);
        din_vld = 1'b1; frame_no = f; ch_no = c; din = d;
        @(negedge clk);
        din_vld = 1'b0;
        check(dout, exp, req);
    endtask

    task automatic wr(input logic h, input logic [4:0] hc, input logic [3:0] hn,
                      input logic s, input logic [4:0] sc, input logic [3:0] sn);
        @(negedge clk);
        hw_en = h; hw_ch = hc; hw_nib = hn; cs_en = s; cs_ch = sc; cs_nib = sn;
        @(negedge clk);
        hw_en = 1'b0; cs_en = 1'b0;
    endtask

    task automatic mf_pulse();
        @(negedge clk); mf_start = 1'b1;
        @(negedge clk); mf_start = 1'b0;
    endtask

    // {esf, en, frame[4:0], ch[4:0], din[7:0], exp[7:0], req[3:0]}
    // Active nibbles: ch0=1010 ch2=0011 ch3=0101 ch5=0000 ch7=1111 (clear)
    localparam int NV = 20;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1,1'b1,5'd6, 5'd0,8'hFF,8'hFF,4'd3},  // R3 A=1
        {1'b1,1'b1,5'd6, 5'd0,8'h00,8'h01,4'd3},  // R3 A=1
        {1'b1,1'b1,5'd12,5'd0,8'hFF,8'hFE,4'd3},  // R3 B=0
        {1'b1,1'b1,5'd18,5'd0,8'h00,8'h01,4'd3},  // R3 C=1
        {1'b1,1'b1,5'd24,5'd0,8'hFF,8'hFE,4'd3},  // R3 D=0
        {1'b1,1'b1,5'd5, 5'd0,8'h00,8'h00,4'd2},  // R2 non-signaling frame
        {1'b1,1'b1,5'd1, 5'd0,8'h55,8'h55,4'd2},  // R2
        {1'b1,1'b1,5'd6, 5'd3,8'hFF,8'hFE,4'd8},  // R8 host won on ch3
        {1'b1,1'b1,5'd12,5'd3,8'h00,8'h01,4'd8},  // R8
        {1'b1,1'b1,5'd24,5'd3,8'h00,8'h01,4'd8},  // R8
        {1'b1,1'b1,5'd6, 5'd7,8'h00,8'h00,4'd5},  // R5 clear channel
        {1'b1,1'b1,5'd18,5'd7,8'hAA,8'hAA,4'd5},  // R5
        {1'b1,1'b1,5'd6, 5'd5,8'hFF,8'hFE,4'd6},  // R6 stream ignored on ch5
        {1'b1,1'b1,5'd6, 5'd2,8'hFF,8'hFE,4'd8},  // R8 stream won on ch2
        {1'b1,1'b1,5'd18,5'd2,8'h00,8'h01,4'd8},  // R8
        {1'b1,1'b1,5'd24,5'd2,8'hAA,8'hAB,4'd8},  // R8
        {1'b0,1'b1,5'd6, 5'd0,8'h00,8'h01,4'd4},  // R4 A in frame 6
        {1'b0,1'b1,5'd12,5'd3,8'h00,8'h01,4'd4},  // R4 B in frame 12
        {1'b0,1'b1,5'd18,5'd0,8'h00,8'h00,4'd4},  // R4 no insert in frame 18
        {1'b1,1'b0,5'd6, 5'd0,8'h00,8'h00,4'd1}   // R1 disabled
    };

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(dout, 8'h00, 10);
        check({7'b0, dout_vld}, 8'h00, 10);
        rst_n = 1'b1;
        host_src = 24'h000028;   // ch3, ch5 host-sourced
        clear_ch = 24'h000080;   // ch7 clear
        wr(1'b0, 0, 0, 1'b1, 5'd0, 4'b1010);
        wr(1'b1, 5'd3, 4'b0101, 1'b1, 5'd3, 4'b1010);   // R8 same cycle, host wins
        wr(1'b1, 5'd2, 4'b1111, 1'b1, 5'd2, 4'b0011);   // R8 same cycle, stream wins
        wr(1'b0, 0, 0, 1'b1, 5'd7, 4'b1111);
        wr(1'b0, 0, 0, 1'b1, 5'd5, 4'b1111);            // R6 ignored on host channel
        mf_pulse();
        for (int k = 0; k < NV; k++) begin
            esf_sel = VEC[k][31];
            rob_en  = VEC[k][30];
            send(VEC[k][29:25], VEC[k][24:20], VEC[k][19:12], VEC[k][11:4], int'(VEC[k][3:0]));
        end
        rob_en = 1'b1; esf_sel = 1'b1;
        // R10 one-cycle latency and valid
        @(negedge clk);
        din_vld = 1'b1; frame_no = 5'd6; ch_no = 5'd0; din = 8'h10;
        @(negedge clk);
        din_vld = 1'b0; din = 8'hFF;
        check(dout, 8'h11, 10);
        check({7'b0, dout_vld}, 8'h01, 10);
        @(negedge clk);
        check(dout, 8'h11, 10);
        check({7'b0, dout_vld}, 8'h00, 10);
        // R9 store change after snapshot not used until next pulse
        wr(1'b0, 0, 0, 1'b1, 5'd0, 4'b0101);
        send(5'd6, 5'd0, 8'h00, 8'h01, 9);
        mf_pulse();
        send(5'd6, 5'd0, 8'h00, 8'h00, 9);
        send(5'd12, 5'd0, 8'h00, 8'h01, 9);
        // R7 host write ignored on stream channel
        wr(1'b1, 5'd0, 4'b1111, 1'b0, 0, 0);
        mf_pulse();
        send(5'd6, 5'd0, 8'h00, 8'h00, 7);
        // R6 host write takes effect on host channel
        wr(1'b1, 5'd5, 4'b1000, 1'b0, 0, 0);
        mf_pulse();
        send(5'd6, 5'd5, 8'h00, 8'h01, 6);
        send(5'd12, 5'd5, 8'hFF, 8'hFE, 6);
        summary();
    end
endmodule